// File: doc/BRIEF.md
# Programmable Sum-of-Products Array with Serial Fuse Map

This block is the logic core of a one-time-programmable logic device, rebuilt as ordinary registers and gates. Twelve dedicated inputs and ten feedback signals are expanded into their true and inverted forms. The result is 44 array lines. A connection map holds one bit per line for each product term, and each term is the AND of the lines it connects.

There are 132 terms in all. The first 120 are ORed in fixed, uneven groups to form ten sum outputs. The next ten drive one enable term per output. The last two are the global set term and the global clear term. These signals go to output cells outside this block.

The connection map is written through a one-bit serial port, and the same port reads it back. A security bit, once set, freezes the map and silences readback until the next reset. The array has no clock inside its evaluation path, so its outputs follow the inputs and the map within the same cycle.

Top module: `pla_core`

## Requirements
- R1: Signal s (dedicated inputs at s = 0..11, feedback inputs at s = 12..21) drives array line 2s with its true value and line 2s+1 with its inverse. Every term output is the AND of its connected lines and changes in the same cycle as `ded_i`/`fb_i`, with no clock edge in between.
- R2: A term whose map row is all zero evaluates to 1 for every input pattern.
- R3: A term connected to both lines of the same signal evaluates to 0 for every input pattern.
- R4: Sum output k is the OR of a contiguous run of terms starting at term 0, in output order. The run lengths are 8, 10, 12, 14, 16, 16, 14, 12, 10, 8 for k = 0..9, so output 0 uses terms 0..7 and output 9 uses terms 112..119.
- R5: Terms 120..129 drive `oe_o[0]`..`oe_o[9]`, term 130 drives `gset_o` and term 131 drives `gclr_o`.
- R6: The map bit of term t and line l sits at flat index f = 44t + l, where a 1 means connected. On each rising edge with `cfg_en` high and the security bit clear, bit f moves to f+1 and `cfg_din` enters at f = 0. After 5808 shifts, the first bit sent therefore sits at f = 5807.
- R7: While the security bit is clear, `cfg_dout` shows map bit f = 5807. Shifting therefore streams the old map out, highest index first.
- R8: A rising edge with `cfg_lock` high sets the security bit, which stays set until reset. While it is set, `cfg_en` has no effect on the map or on any array output, and `cfg_dout` is 0.
- R9: A rising edge with `rst` high clears the whole map and the security bit. Every sum, enable and global term then reads 1 and `cfg_dout` reads 0.
- R10: On an edge with `cfg_en` low, the map keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset of map and security bit |
| ded_i | input | 12 | Dedicated array inputs |
| fb_i | input | 10 | Feedback inputs from the output cells |
| cfg_en | input | 1 | Shift the map by one position on this edge |
| cfg_din | input | 1 | Serial map bit entering at index 0 |
| cfg_lock | input | 1 | Set the security bit on this edge |
| cfg_dout | output | 1 | Serial readback of the top map bit, 0 when secured |
| sum_o | output | 10 | OR-group sums, one per output |
| oe_o | output | 10 | Per-output enable terms |
| gset_o | output | 1 | Global set term |
| gclr_o | output | 1 | Global clear term |

## Verification
The bench builds the block with its default parameters: 12 dedicated inputs, 10 feedback inputs, 10 outputs, a minimum group of 8 and a step of 2. This gives the full 5808-bit chain and the two 16-term middle groups. A complete serial load, and readback of the loaded bits in order, can therefore be observed end to end, together with the boundaries between unequal groups. A sparse pseudo-random map, with forced empty and self-contradicting rows, tests every group edge against a behavioural model held in a queue. A later all-ones load after reset shows that the security bit is cleared and that every term collapses to zero.

// File: rtl/pla_pkg.sv
package pla_pkg;

    // Default geometry of the array
    localparam int DED_DEF      = 12;
    localparam int FB_DEF       = 10;
    localparam int OUT_DEF      = 10;
    localparam int FAN_MIN_DEF  = 8;
    localparam int FAN_STEP_DEF = 2;
    localparam int N_GLOBAL     = 2;   // set term, clear term

    // One configuration-port request sampled per edge
    typedef struct packed {
        logic shift;
        logic din;
        logic lock;
    } cfg_req_t;

    // The two global control terms
    typedef struct packed {
        logic gset;
        logic gclr;
    } glob_terms_t;

    // Fan-in of output k: grows toward the middle, mirrored on the far side
    function automatic int fan_of(int k, int n_out, int fmin, int fstep);
        int m;
        m = (k < n_out / 2) ? k : (n_out - 1 - k);
        return fmin + fstep * m;
    endfunction

    // First term index of output k
    function automatic int fan_base(int k, int n_out, int fmin, int fstep);
        int acc;
        acc = 0;
        for (int j = 0; j < k; j++) begin
            acc += fan_of(j, n_out, fmin, fstep);
        end
        return acc;
    endfunction

    // Number of terms feeding all sums
    function automatic int sum_terms(int n_out, int fmin, int fstep);
        return fan_base(n_out, n_out, fmin, fstep);
    endfunction

    function automatic int line_true(int s);
        return 2 * s;
    endfunction

    function automatic int line_comp(int s);
        return 2 * s + 1;
    endfunction

endpackage

// File: rtl/pla_lines.sv
module pla_lines
    import pla_pkg::*;
#(
    parameter int N_DED = DED_DEF,
    parameter int N_FB  = FB_DEF,
    localparam int N_SIG  = N_DED + N_FB,
    localparam int N_LINE = 2 * N_SIG
) (
    input  logic [N_DED-1:0]  ded_i,
    input  logic [N_FB-1:0]   fb_i,
    output logic [N_LINE-1:0] lines_o
);

    logic [N_SIG-1:0] sig;
    assign sig = {fb_i, ded_i};

    for (genvar s = 0; s < N_SIG; s++) begin : g_sig
        assign lines_o[line_true(s)] = sig[s];
        assign lines_o[line_comp(s)] = ~sig[s];
    end

endmodule

// File: rtl/pla_fuse_chain.sv
module pla_fuse_chain
    import pla_pkg::*;
#(
    parameter int N_TERM = 132,
    parameter int N_LINE = 44,
    localparam int N_BITS = N_TERM * N_LINE
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_req_t          req,
    output logic [N_BITS-1:0] map_o,
    output logic              locked_o,
    output logic              dout_o
);

    logic [N_BITS-1:0] map_q;
    logic              lock_q;
    logic              step;

    assign step = req.shift & ~lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= '0;
        end else if (step) begin
            map_q <= {map_q[N_BITS-2:0], req.din};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
        end else if (req.lock) begin
            lock_q <= 1'b1;
        end
    end

    assign map_o    = map_q;
    assign locked_o = lock_q;
    assign dout_o   = lock_q ? 1'b0 : map_q[N_BITS-1];

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
    import pla_pkg::*;
#(
    parameter int N_TERM = 132,
    parameter int N_LINE = 44,
    localparam int N_BITS = N_TERM * N_LINE
) (
    input  logic [N_LINE-1:0] lines_i,
    input  logic [N_BITS-1:0] map_i,
    output logic [N_TERM-1:0] terms_o
);

    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_LINE-1:0] row;
        assign row        = map_i[t*N_LINE +: N_LINE];
        // unconnected lines read as 1, so an empty row gives 1
        assign terms_o[t] = &(lines_i | ~row);
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
    import pla_pkg::*;
#(
    parameter int N_OUT    = OUT_DEF,
    parameter int FAN_MIN  = FAN_MIN_DEF,
    parameter int FAN_STEP = FAN_STEP_DEF,
    localparam int N_SUM   = sum_terms(N_OUT, FAN_MIN, FAN_STEP)
) (
    input  logic [N_SUM-1:0] terms_i,
    output logic [N_OUT-1:0] sums_o
);

    for (genvar k = 0; k < N_OUT; k++) begin : g_sum
        localparam int BASE = fan_base(k, N_OUT, FAN_MIN, FAN_STEP);
        localparam int FAN  = fan_of(k, N_OUT, FAN_MIN, FAN_STEP);
        assign sums_o[k] = |terms_i[BASE +: FAN];
    end

endmodule

// File: rtl/pla_core.sv
module pla_core
    import pla_pkg::*;
#(
    parameter int N_DED    = DED_DEF,
    parameter int N_FB     = FB_DEF,
    parameter int N_OUT    = OUT_DEF,
    parameter int FAN_MIN  = FAN_MIN_DEF,
    parameter int FAN_STEP = FAN_STEP_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DED-1:0] ded_i,
    input  logic [N_FB-1:0]  fb_i,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic             cfg_lock,
    output logic             cfg_dout,
    output logic [N_OUT-1:0] sum_o,
    output logic [N_OUT-1:0] oe_o,
    output logic             gset_o,
    output logic             gclr_o
);

    localparam int N_LINE = 2 * (N_DED + N_FB);
    localparam int N_SUM  = sum_terms(N_OUT, FAN_MIN, FAN_STEP);
    localparam int N_TERM = N_SUM + N_OUT + N_GLOBAL;
    localparam int N_BITS = N_TERM * N_LINE;

    logic [N_LINE-1:0] lines_w;
    logic [N_BITS-1:0] map_w;
    logic [N_TERM-1:0] terms_w;
    logic              lock_w;
    cfg_req_t          req_w;
    glob_terms_t       glob_w;

    assign req_w = '{shift: cfg_en, din: cfg_din, lock: cfg_lock};

    pla_lines #(.N_DED(N_DED), .N_FB(N_FB)) u_lines (
        .ded_i   (ded_i),
        .fb_i    (fb_i),
        .lines_o (lines_w)
    );

    pla_fuse_chain #(.N_TERM(N_TERM), .N_LINE(N_LINE)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .req      (req_w),
        .map_o    (map_w),
        .locked_o (lock_w),
        .dout_o   (cfg_dout)
    );

    pla_and_plane #(.N_TERM(N_TERM), .N_LINE(N_LINE)) u_and (
        .lines_i (lines_w),
        .map_i   (map_w),
        .terms_o (terms_w)
    );

    pla_or_plane #(.N_OUT(N_OUT), .FAN_MIN(FAN_MIN), .FAN_STEP(FAN_STEP)) u_or (
        .terms_i (terms_w[N_SUM-1:0]),
        .sums_o  (sum_o)
    );

    assign oe_o        = terms_w[N_SUM +: N_OUT];
    assign glob_w.gset = terms_w[N_SUM + N_OUT];
    assign glob_w.gclr = terms_w[N_SUM + N_OUT + 1];
    assign gset_o      = glob_w.gset;
    assign gclr_o      = glob_w.gclr;

endmodule

// File: rtl/pla_core_chk.sv
module pla_core_chk #(
    parameter int N_BITS = 5808,
    parameter int N_OUT  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_en,
    input logic              cfg_din,
    input logic              cfg_lock,
    input logic              cfg_dout,
    input logic              locked,
    input logic [N_BITS-1:0] map,
    input logic [N_OUT-1:0]  sum_o,
    input logic [N_OUT-1:0]  oe_o,
    input logic              gset_o,
    input logic              gclr_o
);

    // R6: the serial bit lands at index 0
    a_r6_entry_bit: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && !locked) |=> (map[0] == $past(cfg_din)));

    // R6: every other bit moves up by one
    a_r6_chain_moves: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && !locked) |=> (map[N_BITS-1:1] == $past(map[N_BITS-2:0])));

    // R10: no shift request, no change
    a_r10_map_holds: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(map));

    // R8: the security bit is set by a lock request and never drops
    a_r8_lock_takes: assert property (@(posedge clk) disable iff (rst)
        cfg_lock |=> locked);

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    a_r8_map_frozen: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(map));

    a_r8_readback_quiet: assert property (@(posedge clk) disable iff (rst)
        locked |-> !cfg_dout);

    // R9: reset empties the map and clears the security bit
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (map == '0 && !locked));

    // R2: an empty map makes every term read one
    a_r2_blank_ones: assert property (@(posedge clk) disable iff (rst)
        (map == '0) |-> (&sum_o && &oe_o && gset_o && gclr_o));

endmodule

bind pla_core pla_core_chk #(.N_BITS(N_BITS), .N_OUT(N_OUT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_din  (cfg_din),
    .cfg_lock (cfg_lock),
    .cfg_dout (cfg_dout),
    .locked   (lock_w),
    .map      (map_w),
    .sum_o    (sum_o),
    .oe_o     (oe_o),
    .gset_o   (gset_o),
    .gclr_o   (gclr_o)
);

// File: tb/sim_pla_core.sv
`timescale 1ns/1ps
module sim_pla_core;

    localparam int NT = 132;
    localparam int NL = 44;
    localparam int NB = NT * NL;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [11:0] ded_i = '0;
    logic [9:0]  fb_i = '0;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic       cfg_lock = 1'b0;
    logic       cfg_dout;
    logic [9:0] sum_o;
    logic [9:0] oe_o;
    logic       gset_o;
    logic       gclr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit model_ok = 1'b0;
    string cur_req = "R9";

    bit mq[$];
    bit mlock = 1'b0;
    bit tgt [NB];
    int fan_tab [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
    int unsigned rs = 32'h1234_5678;

    always #4 clk = ~clk;

    pla_core u0 (
        .clk(clk), .rst(rst), .ded_i(ded_i), .fb_i(fb_i),
        .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_lock(cfg_lock),
        .cfg_dout(cfg_dout), .sum_o(sum_o), .oe_o(oe_o),
        .gset_o(gset_o), .gclr_o(gclr_o)
    );

    function automatic int unsigned nrand();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // reference model: one queue entry per map bit
    always @(posedge clk) begin
        if (rst) begin
            mq = {};
            for (int f = 0; f < NB; f++) mq.push_back(1'b0);
            mlock = 1'b0;
            model_ok = 1'b1;
        end else begin
            if (cfg_en && !mlock) begin
                mq.push_front(cfg_din);
                void'(mq.pop_back());
            end
            if (cfg_lock) mlock = 1'b1;
        end
    end

    function automatic bit term_val(int t);
        bit v;
        bit lv;
        bit sv;
        v = 1'b1;
        for (int l = 0; l < NL; l++) begin
            if (mq[t*NL + l]) begin
                sv = (l / 2 < 12) ? ded_i[l/2] : fb_i[l/2 - 12];
                lv = (l % 2 == 1) ? !sv : sv;
                if (!lv) v = 1'b0;
            end
        end
        return v;
    endfunction

    always @(negedge clk) begin
        if (model_ok && !rst) begin
            logic [9:0] es;
            logic [9:0] eo;
            int base;
            base = 0;
            for (int k = 0; k < 10; k++) begin
                es[k] = 1'b0;
                for (int j = 0; j < fan_tab[k]; j++) es[k] = es[k] | term_val(base + j);
                base += fan_tab[k];
            end
            for (int k = 0; k < 10; k++) eo[k] = term_val(120 + k);
            chk({cur_req, "/R4 sums"}, 32'(sum_o), 32'(es));
            chk({cur_req, "/R5 controls"}, {20'd0, oe_o, gset_o, gclr_o},
                {20'd0, eo, term_val(130), term_val(131)});
            chk({cur_req, mlock ? "/R8 readback" : "/R7 readback"},
                32'(cfg_dout), mlock ? 32'd0 : 32'(mq[NB-1]));
        end
    end

    task automatic load_tgt();
        cfg_en = 1'b1;
        for (int f = NB - 1; f >= 0; f--) begin
            cfg_din = tgt[f];
            step();
        end
        cfg_en = 1'b0;
        cfg_din = 1'b0;
    endtask

    task automatic clear_row(int t);
        for (int l = 0; l < NL; l++) tgt[t*NL + l] = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        @(negedge clk);
        chk("R9 sums after reset", 32'(sum_o), 32'h3FF);
        chk("R9 enables after reset", 32'(oe_o), 32'h3FF);
        chk("R9 globals after reset", {30'd0, gset_o, gclr_o}, 32'd3);
        chk("R9 readback after reset", 32'(cfg_dout), 32'd0);
        cur_req = "R2";
        for (int i = 0; i < 10; i++) begin
            ded_i = 12'(nrand()); fb_i = 10'(nrand());
            step();
        end

        // sparse random map with forced corner rows
        for (int f = 0; f < NB; f++) tgt[f] = (nrand() % 12) == 0;
        clear_row(3);   tgt[3*NL + 6] = 1'b1; tgt[3*NL + 7] = 1'b1;
        clear_row(120); tgt[120*NL + 0] = 1'b1; tgt[120*NL + 25] = 1'b1;
        clear_row(121);
        clear_row(130); tgt[130*NL + 28] = 1'b1; tgt[130*NL + 29] = 1'b1;
        cur_req = "R6";
        load_tgt();

        cur_req = "R1";
        for (int i = 0; i < 200; i++) begin
            ded_i = 12'(nrand()); fb_i = 10'(nrand());
            @(negedge clk);
            chk("R1 enable0 = ded0 & ~fb0", 32'(oe_o[0]), 32'(ded_i[0] & ~fb_i[0]));
            chk("R2 empty row reads one", 32'(oe_o[1]), 32'd1);
            chk("R3 contradiction reads zero", 32'(gset_o), 32'd0);
            step();
        end

        // readback streams the loaded bits highest index first
        cur_req = "R7";
        cfg_en = 1'b1;
        cfg_din = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            chk("R7 streamed bit", 32'(cfg_dout), 32'(tgt[NB - 1 - i]));
            step();
        end
        cfg_en = 1'b0;

        cur_req = "R10";
        for (int i = 0; i < 50; i++) begin
            ded_i = 12'(nrand()); fb_i = 10'(nrand());
            cfg_din = nrand() % 2 == 0;
            step();
        end

        // secure the map, then try to shift
        cur_req = "R8";
        cfg_lock = 1'b1;
        step();
        cfg_lock = 1'b0;
        cfg_en = 1'b1;
        for (int i = 0; i < 200; i++) begin
            cfg_din = nrand() % 2 == 0;
            ded_i = 12'(nrand()); fb_i = 10'(nrand());
            @(negedge clk);
            chk("R8 readback silenced", 32'(cfg_dout), 32'd0);
            step();
        end
        cfg_en = 1'b0;

        // reset releases the security bit
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        cur_req = "R9";
        @(negedge clk);
        chk("R9 sums cleared", 32'(sum_o), 32'h3FF);
        chk("R9 readback cleared", 32'(cfg_dout), 32'd0);
        for (int f = 0; f < NB; f++) tgt[f] = 1'b1;
        load_tgt();
        @(negedge clk);
        chk("R3 all-connected sums", 32'(sum_o), 32'd0);
        chk("R3 all-connected controls", {20'd0, oe_o, gset_o, gclr_o}, 32'd0);
        chk("R9 unlocked readback", 32'(cfg_dout), 32'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule